// File: doc/BRIEF.md
# Ordered Store Buffer with Write-to-Read Fence

This block sits between a core's commit stage and its data cache. A committing store is accepted into a small FIFO and leaves the commit order at once. Later instructions can then retire while the store still waits for the cache. The buffer hands stores to the cache one at a time, oldest first, and removes each one only when the cache acknowledges it. Stores therefore reach memory in program order. Loads never wait for buffered stores, so a read may overtake an older write, and that is the only reordering the block allows.

A load presents its address to a combinational lookup. If one or more buffered stores target that address, the youngest of them supplies the data and the cache is not read. A write-to-read fence pulse makes the block hold younger loads. The stall output stays high until every store that was older than the fence has been acknowledged. A read-modify-write request is granted only when the buffer is empty, so it performs behind all earlier stores.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, and `cache_wr_valid`, `ld_hit` and `fence_stall` are 0.
- R2: A store is accepted on a rising edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly while DEPTH stores are held. A store offered while `st_ready` is 0 is dropped and never reaches the cache.
- R3: `cache_wr_valid` is 1 whenever at least one store is held. `cache_wr_addr`/`cache_wr_data` present the stores in the order they were accepted.
- R4: The head store stays on the cache port, unchanged, until a cycle with `cache_wr_ack` at 1. Each acknowledgment removes exactly one store.
- R5: In the same cycle as `ld_addr`, `ld_hit` is 1 if any held store has that address, and `ld_data` is the data of the most recently accepted such store.
- R6: `ld_hit` is 0 when no held store matches, including an address whose stores have already drained.
- R7: When `fence_in` is 1 and stores are pending, `fence_stall` is 1 in that same cycle. Pending stores are those held, plus one accepted in the same cycle. The stall stays 1 until the edge that drains the last of those stores, and it drops even if stores accepted after the fence are still held.
- R8: `fence_in` with an empty buffer and no store accepted in that cycle leaves `fence_stall` at 0.
- R9: `rmw_go` is 1 exactly when `rmw_valid` is 1 and the buffer holds no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Committing store offered |
| st_ready | output | 1 | Buffer has room for a store |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| cache_wr_valid | output | 1 | Oldest held store offered to the cache |
| cache_wr_ack | input | 1 | Cache accepts the offered store |
| cache_wr_addr | output | 16 | Address of the oldest held store |
| cache_wr_data | output | 32 | Data of the oldest held store |
| ld_addr | input | 16 | Address of the load being looked up |
| ld_hit | output | 1 | A held store matches the load address |
| ld_data | output | 32 | Data of the youngest matching store |
| fence_in | input | 1 | Write-to-read fence seen (one-cycle pulse) |
| fence_stall | output | 1 | Younger loads must wait |
| rmw_valid | input | 1 | Read-modify-write requests to perform |
| rmw_go | output | 1 | Read-modify-write may perform |

## Verification
On every cycle, the assertions compare the handshake flags with an occupancy count kept by the checker. They confirm that the head store holds steady while it waits for an acknowledgment, that the fence stall only rises with a fence, and that the read-modify-write grant tracks an empty buffer. Some behaviour only the bench's directed scenarios can show. This covers the exact drain order, which of several same-address stores forwards its data, and that a dropped store never appears. It also covers the fence releasing after exactly the older stores even though younger ones remain.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    localparam int TSB_ADDR_W = 16;
    localparam int TSB_DATA_W = 32;

    typedef struct packed {
        logic [TSB_ADDR_W-1:0] addr;
        logic [TSB_DATA_W-1:0] data;
    } tsb_entry_t;
endpackage

// File: rtl/tsb_fifo.sv
// Circular store queue; DEPTH must be a power of two so pointers wrap freely.
module tsb_fifo
    import tsb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  tsb_entry_t    push_entry,
    input  logic          pop,
    output tsb_entry_t    slots [DEPTH],
    output logic [IW-1:0] head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [CW-1:0] count;
    } ptr_t;

    ptr_t       ptr_d, ptr_q;
    tsb_entry_t mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.tail = ptr_q.tail + IW'(1);
        if (pop)  ptr_d.head = ptr_q.head + IW'(1);
        ptr_d.count = ptr_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[ptr_q.tail] <= push_entry;
    end

    assign slots = mem_q;
    assign head  = ptr_q.head;
    assign count = ptr_q.count;
endmodule

// File: rtl/tsb_forward.sv
// Youngest-match search: scan oldest to youngest, later matches overwrite.
module tsb_forward
    import tsb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  tsb_entry_t            slots [DEPTH],
    input  logic [IW-1:0]         head,
    input  logic [CW-1:0]         count,
    input  logic [TSB_ADDR_W-1:0] ld_addr,
    output logic                  hit,
    output logic [TSB_DATA_W-1:0] data
);
    always_comb begin
        logic [IW-1:0] idx;
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IW'(k);
            if ((CW'(k) < count) && (slots[idx].addr == ld_addr)) begin
                hit  = 1'b1;
                data = slots[idx].data;
            end
        end
    end
endmodule

// File: rtl/tsb_fence.sv
// Counts the stores older than the most recent fence down to zero.
module tsb_fence #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fence_in,
    input  logic          st_fire,
    input  logic          drain_fire,
    input  logic [CW-1:0] occupancy,
    output logic          stall
);
    typedef struct packed {
        logic [CW-1:0] older;
    } fence_t;

    fence_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (fence_in)
            f_d.older = occupancy + CW'(st_fire) - CW'(drain_fire);
        else if (drain_fire && (f_q.older != '0))
            f_d.older = f_q.older - CW'(1);
        stall = (f_q.older != '0) || (fence_in && ((occupancy != '0) || st_fire));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
    import tsb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [TSB_ADDR_W-1:0] st_addr,
    input  logic [TSB_DATA_W-1:0] st_data,
    output logic                  cache_wr_valid,
    input  logic                  cache_wr_ack,
    output logic [TSB_ADDR_W-1:0] cache_wr_addr,
    output logic [TSB_DATA_W-1:0] cache_wr_data,
    input  logic [TSB_ADDR_W-1:0] ld_addr,
    output logic                  ld_hit,
    output logic [TSB_DATA_W-1:0] ld_data,
    input  logic                  fence_in,
    output logic                  fence_stall,
    input  logic                  rmw_valid,
    output logic                  rmw_go
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tsb_entry_t    slots [DEPTH];
    tsb_entry_t    push_entry;
    logic [IW-1:0] head;
    logic [CW-1:0] count;
    logic          st_fire, drain_fire;

    assign st_ready       = (count != CW'(DEPTH));
    assign st_fire        = st_valid && st_ready;
    assign cache_wr_valid = (count != '0);
    assign drain_fire     = cache_wr_valid && cache_wr_ack;
    assign push_entry     = '{addr: st_addr, data: st_data};
    assign cache_wr_addr  = slots[head].addr;
    assign cache_wr_data  = slots[head].data;
    assign rmw_go         = rmw_valid && (count == '0);

    tsb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(st_fire), .push_entry(push_entry),
        .pop(drain_fire), .slots(slots), .head(head), .count(count)
    );

    tsb_forward #(.DEPTH(DEPTH)) u_fwd (
        .slots(slots), .head(head), .count(count), .ld_addr(ld_addr),
        .hit(ld_hit), .data(ld_data)
    );

    tsb_fence #(.DEPTH(DEPTH)) u_fence (
        .clk(clk), .rst_n(rst_n), .fence_in(fence_in), .st_fire(st_fire),
        .drain_fire(drain_fire), .occupancy(count), .stall(fence_stall)
    );
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker
    import tsb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic                  st_ready,
    input logic                  cache_wr_valid,
    input logic                  cache_wr_ack,
    input logic [TSB_ADDR_W-1:0] cache_wr_addr,
    input logic [TSB_DATA_W-1:0] cache_wr_data,
    input logic                  fence_in,
    input logic                  fence_stall,
    input logic                  rmw_valid,
    input logic                  rmw_go
);
    int occ_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_m <= 0;
        else        occ_m <= occ_m + int'(st_valid && st_ready)
                                   - int'(cache_wr_valid && cache_wr_ack);
    end

    a_r2_ready_tracks_room: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready == (occ_m < DEPTH));

    a_r3_offer_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid == (occ_m != 0));

    a_r4_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid && !cache_wr_ack |=>
            cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_data));

    a_r7_stall_needs_fence: assert property (@(posedge clk) disable iff (!rst_n)
        !fence_stall |=> (!fence_stall || fence_in));

    a_r8_empty_fence_free: assert property (@(posedge clk) disable iff (!rst_n)
        fence_in && (occ_m == 0) && !(st_valid && st_ready) |-> !fence_stall);

    a_r9_rmw_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_go == (rmw_valid && (occ_m == 0)));
endmodule

bind tso_store_buffer tsb_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tso_store_buffer_test.sv
module tso_store_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, cache_wr_ack = 1'b0, fence_in = 1'b0, rmw_valid = 1'b0;
    logic [15:0] st_addr = '0, ld_addr = '0;
    logic [31:0] st_data = '0;
    logic        st_ready, cache_wr_valid, ld_hit, fence_stall, rmw_go;
    logic [15:0] cache_wr_addr;
    logic [31:0] cache_wr_data, ld_data;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tso_store_buffer #(.DEPTH(4)) uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_one(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check("R1 st_ready", st_ready, 1);
        check("R1 cache_wr_valid", cache_wr_valid, 0);
        check("R1 ld_hit", ld_hit, 0);
        check("R1 fence_stall", fence_stall, 0);
    endtask

    task automatic t_fill_forward;
        push_one(16'h0010, 32'h1);
        push_one(16'h0020, 32'h2);
        push_one(16'h0010, 32'h3);
        push_one(16'h0030, 32'h4);
        @(negedge clk);
        st_valid = 1'b1; st_addr = 16'h0099; st_data = 32'h99; #1;
        check("R2 full not ready", st_ready, 0);
        @(posedge clk); #1; st_valid = 1'b0;
        @(negedge clk);
        ld_addr = 16'h0010; #1;
        check("R5 youngest hit", ld_hit, 1);
        check("R5 youngest data", ld_data, 32'h3);
        ld_addr = 16'h0020; #1;
        check("R5 single match", ld_data, 32'h2);
        ld_addr = 16'h0040; #1;
        check("R6 no match", ld_hit, 0);
        ld_addr = 16'h0099; #1;
        check("R2 dropped store not held", ld_hit, 0);
    endtask

    task automatic t_fence_drain;
        logic [15:0] ea [4] = '{16'h0010, 16'h0020, 16'h0010, 16'h0030};
        @(negedge clk);
        fence_in = 1'b1; #1;
        check("R7 stall on fence", fence_stall, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fence_in = 1'b0; cache_wr_ack = 1'b1; #1;
            check("R3 drain valid", cache_wr_valid, 1);
            check("R3 drain order addr", cache_wr_addr, ea[i]);
            check("R3 drain order data", cache_wr_data, 32'(i + 1));
            check("R7 stall held", fence_stall, 1);
        end
        @(negedge clk);
        cache_wr_ack = 1'b0; #1;
        check("R2 dropped store never drains", cache_wr_valid, 0);
        check("R7 stall released", fence_stall, 0);
        ld_addr = 16'h0010; #1;
        check("R6 drained address misses", ld_hit, 0);
    endtask

    task automatic t_hold;
        push_one(16'h00A0, 32'h5);
        push_one(16'h00B0, 32'h6);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check("R4 head addr held", cache_wr_addr, 16'h00A0);
            check("R4 head data held", cache_wr_data, 32'h5);
        end
        @(negedge clk); cache_wr_ack = 1'b1;
        @(posedge clk); #1; cache_wr_ack = 1'b0;
        @(negedge clk); #1;
        check("R4 one entry per ack", cache_wr_addr, 16'h00B0);
        check("R4 still valid", cache_wr_valid, 1);
        rmw_valid = 1'b1; #1;
        check("R9 rmw waits", rmw_go, 0);
        cache_wr_ack = 1'b1;
        @(posedge clk); #1; cache_wr_ack = 1'b0;
        @(negedge clk); #1;
        check("R9 rmw granted when empty", rmw_go, 1);
        rmw_valid = 1'b0;
    endtask

    task automatic t_fence_partial;
        @(negedge clk);
        fence_in = 1'b1; #1;
        check("R8 empty fence no stall", fence_stall, 0);
        @(negedge clk); fence_in = 1'b0;
        push_one(16'h0050, 32'h7);
        push_one(16'h0060, 32'h8);
        @(negedge clk);
        fence_in = 1'b1; st_valid = 1'b1; st_addr = 16'h0070; st_data = 32'h9; #1;
        check("R7 stall with same-cycle store", fence_stall, 1);
        @(negedge clk);
        fence_in = 1'b0; st_addr = 16'h0080; st_data = 32'hA; cache_wr_ack = 1'b1; #1;
        check("R7 stall after fence", fence_stall, 1);
        @(negedge clk);
        st_valid = 1'b0; #1;
        check("R7 stall two older left", fence_stall, 1);
        @(negedge clk); #1;
        check("R7 stall last older", fence_stall, 1);
        check("R3 third store at head", cache_wr_addr, 16'h0070);
        @(negedge clk); cache_wr_ack = 1'b0; #1;
        check("R7 released with younger held", fence_stall, 0);
        check("R3 younger store still offered", cache_wr_addr, 16'h0080);
        ld_addr = 16'h0080; #1;
        check("R5 forward younger store", ld_data, 32'hA);
        cache_wr_ack = 1'b1;
        @(posedge clk); #1; cache_wr_ack = 1'b0;
        @(negedge clk); #1;
        check("R3 empty after drain", cache_wr_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill_forward();
        t_fence_drain();
        t_hold();
        t_fence_partial();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule